// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

A 32-pin general-purpose I/O controller on a simple 32-bit register bus. The bus has an address, a write strobe, write data and read data. A write takes effect at the rising clock edge while the strobe is high. Read data is combinational from the address, so it is valid within the same cycle.

The pins are grouped into four identical banks of eight. Each bank has its own 64-byte register window. In that window, software controls:

- direction and output value per pin;
- reads of the synchronized pin levels;
- edge or level triggering per pin;
- a sticky per-pin status;
- a mask. Bits are set through one register and cleared through a second, write-only register.

A single interrupt line reports any status bit that is not masked, in any bank.

Pin inputs pass through a two-flop synchronizer before they are read or used for detection. Edge-triggered pins latch status on a rising edge of the synchronized level. Level-triggered pins re-assert status every cycle that the level is high.

Top module: `banked_gpio`

## Requirements
- R1: After reset:
  - every mask bit is 1;
  - every direction bit is 1 (all pins input, `pin_oe` all 0);
  - output, trigger-mode and status registers are 0;
  - `irq` is 0.
- R2: Bank addressing follows these rules:
  - Pin n belongs to bank n>>3, bit n&7.
  - Bank k's window starts at byte address k*0x40 (address bits 7:6 select the bank, bits 5:0 the offset).
  - Only write-data bits 7:0 are used, and read-data bits 31:8 are always 0.
- R3: Offset 0x10 is the direction register, readable and writable. A 1 makes the pin an input. `pin_oe` of a pin is the inverse of its direction bit, from the cycle after the write.
- R4: Offset 0x14 is the output register, readable and writable. It drives `pin_out` from the cycle after the write.
- R5: Offset 0x18 returns the pin levels after a two-flop synchronizer. A change of `pin_in` is first visible there after the second rising clock edge. Writes to 0x18 have no effect.
- R6: Offset 0x20 holds the trigger mode (1 = level, 0 = edge). For an edge pin, a rising edge of the synchronized level sets the status bit at the third clock edge after `pin_in` rose. A falling or steady level sets nothing.
- R7: Offset 0x04 reads the raw status. Writing it clears exactly the bits written as 1, and bits written as 0 keep their value.
- R8: A level pin sets its status bit on every cycle its synchronized level is high. When a clear and a set of a bit fall in the same cycle, the set wins. The bit stays 1 until it is cleared after the level has gone low.
- R9: For the mask:
  - Writing 1s to offset 0x08 sets those mask bits, and 0x08 reads back the mask.
  - Writing 1s to offset 0x0C clears those mask bits, and 0x0C always reads 0.
- R10: Offset 0x00 reads raw status AND NOT mask.
- R11: `irq` is the OR of the masked status bits of all four banks.
- R12: Reads of any offset not listed above (including unaligned offsets) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: bank in bits 7:6, register offset in bits 5:0 |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data, bits 7:0 used |
| bus_rdata | output | 32 | Read data for the current address |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench times the synchronizer exactly. It reads the input register one edge after a pin change, when a correct design still shows 0, and again one edge later. A one-flop or three-flop synchronizer would show the new level too early or too late.

It clears a level-triggered status bit while the pin is still high and reads it on the very next cycle. A design that lets the clear win would show 0 for a cycle. It also checks that an edge-triggered bit stays clear while the level is held high and that a falling edge sets nothing; a design that treats levels as edges, or either edge as a trigger, fails here.

Partial write-one-to-clear and write-one-to-set patterns are checked against neighbouring bits, across banks, and on the interrupt line. Writes to unused and unaligned offsets are followed by read-back of the real registers, which exposes decode that is too loose.

// File: rtl/banked_gpio.sv
`timescale 1ns/1ps
module banked_gpio #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(BANKS) + 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [BANKS*BANK_W-1:0] pin_in,
  output logic [BANKS*BANK_W-1:0] pin_out,
  output logic [BANKS*BANK_W-1:0] pin_oe,
  output logic              irq
);
  localparam int NPIN = BANKS * BANK_W;
  localparam int BW   = AW - 6;
  localparam logic [5:0] O_MSTAT = 6'h00, O_RAW = 6'h04, O_MSET = 6'h08,
                         O_MCLR  = 6'h0C, O_DIR = 6'h10, O_OUT  = 6'h14,
                         O_IN    = 6'h18, O_LVL = 6'h20;

  logic [NPIN-1:0] mask_q, dir_q, out_q, lvl_q, stat_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q;
  logic [NPIN-1:0] wsel, wdat, wbits, hit;
  logic [BW-1:0]   bank;
  logic [5:0]      off;
  logic [BANK_W-1:0] rsel;
  logic unused_wdata;

  assign bank = bus_addr[AW-1:6];
  assign off  = bus_addr[5:0];
  assign unused_wdata = ^bus_wdata[DATA_W-1:BANK_W];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign wsel[b*BANK_W +: BANK_W] = {BANK_W{bus_we && (bank == BW'(b))}};
    assign wdat[b*BANK_W +: BANK_W] = bus_wdata[BANK_W-1:0];
  end

  assign wbits = wsel & wdat;
  assign hit   = sync2_q & (lvl_q | ~prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      dir_q   <= '1;
      out_q   <= '0;
      lvl_q   <= '0;
      stat_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      stat_q  <= (stat_q & ~((off == O_RAW) ? wbits : '0)) | hit;
      case (off)
        O_MSET:  mask_q <= mask_q | wbits;
        O_MCLR:  mask_q <= mask_q & ~wbits;
        O_DIR:   dir_q  <= (dir_q & ~wsel) | wbits;
        O_OUT:   out_q  <= (out_q & ~wsel) | wbits;
        O_LVL:   lvl_q  <= (lvl_q & ~wsel) | wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (off)
      O_MSTAT: rsel = stat_q[int'(bank)*BANK_W +: BANK_W] & ~mask_q[int'(bank)*BANK_W +: BANK_W];
      O_RAW:   rsel = stat_q[int'(bank)*BANK_W +: BANK_W];
      O_MSET:  rsel = mask_q[int'(bank)*BANK_W +: BANK_W];
      O_DIR:   rsel = dir_q[int'(bank)*BANK_W +: BANK_W];
      O_OUT:   rsel = out_q[int'(bank)*BANK_W +: BANK_W];
      O_IN:    rsel = sync2_q[int'(bank)*BANK_W +: BANK_W];
      O_LVL:   rsel = lvl_q[int'(bank)*BANK_W +: BANK_W];
      default: rsel = '0;
    endcase
    bus_rdata = DATA_W'(rsel);
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq     = |(stat_q & ~mask_q);
endmodule

// File: rtl/banked_gpio_chk.sv
`timescale 1ns/1ps
module banked_gpio_chk #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(BANKS) + 6
)(
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_we,
  input logic [BANK_W-1:0] wr_low,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [BANKS*BANK_W-1:0] pin_in,
  input logic [BANKS*BANK_W-1:0] pin_out,
  input logic [BANKS*BANK_W-1:0] pin_oe,
  input logic              irq
);
  localparam int NPIN = BANKS * BANK_W;
  localparam int BW   = AW - 6;

  logic              lw_q;
  logic [5:0]        lo_q;
  logic [BW-1:0]     lb_q;
  logic [BANK_W-1:0] ld_q, oe_b, out_b, in_b;
  logic [NPIN-1:0]   pd1_q, pd2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lw_q  <= 1'b0;
      lo_q  <= '0;
      lb_q  <= '0;
      ld_q  <= '0;
      pd1_q <= '0;
      pd2_q <= '0;
    end else begin
      lw_q  <= bus_we;
      lo_q  <= bus_addr[5:0];
      lb_q  <= bus_addr[AW-1:6];
      ld_q  <= wr_low;
      pd1_q <= pin_in;
      pd2_q <= pd1_q;
    end
  end

  always_comb begin
    oe_b  = pin_oe[int'(lb_q)*BANK_W +: BANK_W];
    out_b = pin_out[int'(lb_q)*BANK_W +: BANK_W];
    in_b  = pd2_q[int'(bus_addr[AW-1:6])*BANK_W +: BANK_W];
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq));

  p_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_q && lo_q == 6'h10) |-> (oe_b == ~ld_q));

  p_out_follows_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_q && lo_q == 6'h14) |-> (out_b == ld_q));

  p_input_two_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[5:0] == 6'h18) |-> (bus_rdata == DATA_W'(in_b)));

  p_unmask_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[5:0] == 6'h0C) |-> (bus_rdata == '0));

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_addr[5:0] inside {6'h00, 6'h04, 6'h08, 6'h10, 6'h14, 6'h18, 6'h20})
      |-> (bus_rdata == '0));
endmodule

bind banked_gpio banked_gpio_chk #(.BANKS(BANKS), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .wr_low(bus_wdata[BANK_W-1:0]), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/banked_gpio_bench.sv
`timescale 1ns/1ps
module banked_gpio_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  banked_gpio u_banked_gpio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // kind: 0 = read data at addr, 1 = irq, 2 = pin_oe, 3 = pin_out
  task automatic expect_at(input int kind, input logic [7:0] addr,
                           input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = addr;
    bus_we   = 1'b0;
    q.push_back('{kind, exp, tag});
  endtask

  task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    expect_at(0, addr, exp, tag);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr  = addr;
    bus_wdata = data;
    bus_we    = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  initial begin : monitor
    item_t it;
    logic [31:0] act;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        it = q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = {31'b0, irq};
          2: act = pin_oe;
          default: act = pin_out;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    rd(8'h08, 32'hFF, "R1 mask bank0");
    rd(8'hC8, 32'hFF, "R1 mask bank3");
    rd(8'h90, 32'hFF, "R1 dir bank2");
    rd(8'h54, 32'h00, "R1 out bank1");
    rd(8'h44, 32'h00, "R1 status bank1");
    rd(8'hA0, 32'h00, "R1 level bank2");
    expect_at(1, 8'h00, 32'h0, "R1 irq");
    expect_at(2, 8'h00, 32'h0, "R1 oe");
    expect_at(3, 8'h00, 32'h0, "R1 out pins");

    // direction and output
    wr(8'h50, 32'h0F);
    expect_at(2, 8'h50, 32'h0000_F000, "R3 oe bank1");
    rd(8'h50, 32'h0F, "R3 dir readback");
    wr(8'hD4, 32'hA5);
    expect_at(3, 8'hD4, 32'hA500_0000, "R4 out bank3");
    rd(8'hD4, 32'hA5, "R4 out readback");
    wr(8'h54, 32'h04);
    expect_at(3, 8'h54, 32'hA500_0400, "R2 pin10 is bank1 bit2");
    rd(8'h54, 32'h04, "R4 out bank1 readback");

    // synchronizer and edge detection timing
    set_pins(32'h1234_5678);
    rd(8'h18, 32'h00, "R5 input after one edge");
    rd(8'h18, 32'h78, "R5 input after two edges");
    rd(8'h04, 32'h78, "R6 edge status at third edge");
    rd(8'h58, 32'h56, "R5 input bank1");
    rd(8'h98, 32'h34, "R5 input bank2");
    rd(8'hD8, 32'h12, "R5 input bank3");
    wr(8'h18, 32'hFF);
    rd(8'h18, 32'h78, "R5 input write ignored");
    rd(8'h00, 32'h00, "R10 all masked");
    expect_at(1, 8'h00, 32'h0, "R11 irq all masked");

    // partial clear, edge pin held high stays clear
    wr(8'h04, 32'h08);
    rd(8'h04, 32'h70, "R7 partial clear");
    repeat (3) @(negedge clk);
    rd(8'h04, 32'h70, "R6 held level no re-set");

    // mask set / clear
    wr(8'h0C, 32'h30);
    rd(8'h08, 32'hCF, "R9 unmask readback");
    rd(8'h0C, 32'h00, "R9 unmask reads zero");
    rd(8'h00, 32'h30, "R10 masked status");
    expect_at(1, 8'h00, 32'h1, "R11 irq bank0");
    wr(8'h08, 32'h10);
    rd(8'h08, 32'hDF, "R9 mask set");
    rd(8'h00, 32'h20, "R10 masked after set");
    wr(8'h04, 32'h20);
    rd(8'h00, 32'h00, "R10 masked after clear");
    rd(8'h04, 32'h50, "R7 raw after clear");
    expect_at(1, 8'h00, 32'h0, "R11 irq drops");

    // interrupt from another bank
    wr(8'h8C, 32'h04);
    rd(8'h80, 32'h04, "R10 masked bank2");
    expect_at(1, 8'h00, 32'h1, "R11 irq bank2");
    wr(8'h88, 32'h04);
    expect_at(1, 8'h00, 32'h0, "R11 irq bank2 masked");

    // level mode
    wr(8'hE0, 32'h02);
    rd(8'hE0, 32'h02, "R6 level readback");
    wr(8'hC4, 32'h12);
    rd(8'hC4, 32'h02, "R8 set wins over clear");
    set_pins(32'h1034_5670);
    repeat (4) @(negedge clk);
    rd(8'hC4, 32'h02, "R8 sticky after low");
    wr(8'hC4, 32'h02);
    rd(8'hC4, 32'h00, "R8 cleared after low");
    wr(8'h04, 32'hFF);
    repeat (3) @(negedge clk);
    rd(8'h04, 32'h00, "R6 falling edge sets nothing");

    // unmapped offsets
    wr(8'h1C, 32'hFF);
    wr(8'h24, 32'h00);
    wr(8'h11, 32'h00);
    wr(8'h3C, 32'hFF);
    rd(8'h1C, 32'h00, "R12 read 0x1C");
    rd(8'h24, 32'h00, "R12 read 0x24");
    rd(8'h11, 32'h00, "R12 read unaligned");
    rd(8'h10, 32'hFF, "R12 dir untouched");
    rd(8'h08, 32'hDF, "R12 mask untouched");
    rd(8'h20, 32'h00, "R12 level untouched");
    expect_at(3, 8'h00, 32'hA500_0400, "R12 pins untouched");

    // upper write bits dropped
    wr(8'h14, 32'hFFFF_FF01);
    expect_at(3, 8'h14, 32'hA500_0401, "R2 upper bits dropped");
    rd(8'h14, 32'h0000_0001, "R2 upper read zero");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule